// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block turns a single-request internal interface into the strobe sequences that an external asynchronous static RAM of 256K words by 16 bits needs. A requester presents a word address, a read or write flag, write data and a two-bit lane mask under a valid/ready handshake. The controller then runs one access to completion and accepts nothing else until it is done. Reads return the captured word with a one-cycle valid pulse.

On the memory side the controller drives an 18-bit address, active-low chip, write and output enables, and one active-low enable for each byte lane. The shared 16-bit data bus is split into an output value, an output enable and an input value, so that a pad cell can be placed outside the block. Access and write-pulse lengths are whole clock cycles, derived from the access time and the clock period given as parameters.

The state machine has six states. IDLE has every strobe high and accepts requests. Transition *accept-read* goes IDLE→RD_WAIT. In RD_WAIT the chip and output enables are low for the access time; transition *capture* goes RD_WAIT→RD_TURN. RD_TURN releases every strobe for one cycle while the response is presented; transition *turn-done* goes RD_TURN→IDLE. Transition *accept-write* goes IDLE→WR_SETUP. WR_SETUP drives the address, the data and the chip enable with the write enable still high; transition *pulse-start* goes WR_SETUP→WR_PULSE. WR_PULSE holds the write enable low for the pulse length; transition *pulse-end* goes WR_PULSE→WR_HOLD. WR_HOLD raises the write enable while the address and data stay driven; transition *hold-done* goes WR_HOLD→IDLE.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset the chip, write, output and both lane enables are high (1), the data bus output enable is low (0) and req_ready is high.
- R2: A request is taken only in a cycle where req_valid and req_ready are both high. req_ready stays low from the next cycle until the access has returned to IDLE.
- R3: A write runs in three phases. First comes one cycle with chip enable low, write enable high and the data driven. Next, write enable is low for ACC_CYC cycles. Last comes one cycle with write enable high again and chip enable and data still driven. The address does not change while write enable is low.
- R4: Lane mask bit 1 drives the upper lane enable (data bits 15:8) low and bit 0 drives the lower lane enable (bits 7:0) low, for both reads and writes. A mask bit of 1 means the lane is used.
- R5: A read holds chip enable and output enable low with the address for ACC_CYC cycles and samples the data bus at the end of the last of them. rsp_valid is high for exactly one cycle, ACC_CYC+1 cycles after the accepting edge.
- R6: In the returned word, every lane whose mask bit is 0 reads as 0x00, whatever the bus carries.
- R7: The data bus output enable is high only in the three write phases, and never in the cycle right after a cycle with output enable low.
- R8: ACC_CYC equals ceil(ACCESS_PS / CLK_PS), with a minimum of 1. With the defaults (15 ns access, 10 ns clock) it is 2.
- R9: Write enable and output enable are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 1 = bits 15:8, bit 0 = bits 7:0 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Read data, unused lanes zero |
| mem_addr | output | 18 | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_ub_n | output | 1 | Upper lane enable, active low |
| mem_lb_n | output | 1 | Lower lane enable, active low |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data read from the memory bus |

## Verification
A wrong state shows up at once on the strobes, because every memory-side output is decoded from the state register. Examples are a write pulse with no setup cycle, the bus driven during a read, or both enables low together. Each of these appears in the same cycle as the bad state. A timer that ends early lets the capture happen before the memory model's data is valid, so the returned word carries a marker pattern on the next response pulse. A wrong lane mask shows as a nonzero byte in a lane that was not used, or as a byte that did not change when the memory is read back after a partial write.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_WAIT  = 3'd1,
        ST_RD_TURN  = 3'd2,
        ST_WR_SETUP = 3'd3,
        ST_WR_PULSE = 3'd4,
        ST_WR_HOLD  = 3'd5
    } ctrl_state_t;

    // R8: cycles needed to cover a delay, never below one
    function automatic int unsigned cycles_for(input int unsigned delay_ps,
                                               input int unsigned clk_ps);
        int unsigned c;
        c = (delay_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
    parameter int unsigned CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (!rst_n)
            remain <= '0;
        else if (load)
            remain <= LAST;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign done = (remain == '0);
endmodule

// File: rtl/sram_lane_merge.sv
module sram_lane_merge #(
    parameter int unsigned LANES = 2
) (
    input  logic [LANES*8-1:0] raw,
    input  logic [LANES-1:0]   use_lane,
    output logic [LANES*8-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*8 +: 8] = use_lane[g] ? raw[g*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned CLK_PS    = 10000,
    parameter int unsigned ACCESS_PS = 15000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic [DATA_W/8-1:0]    req_mask,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic                   mem_ce_n,
    output logic                   mem_we_n,
    output logic                   mem_oe_n,
    output logic                   mem_ub_n,
    output logic                   mem_lb_n,
    output logic [DATA_W-1:0]      mem_dq_out,
    output logic                   mem_dq_oe,
    input  logic [DATA_W-1:0]      mem_dq_in
);
    localparam int unsigned LANES   = DATA_W / 8;
    localparam int unsigned ACC_CYC = cycles_for(ACCESS_PS, CLK_PS);

    ctrl_state_t state, state_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q, merged;
    logic [LANES-1:0]  mask_q;
    logic              rsp_q;
    logic              accept, tmr_load, tmr_done, active;
    logic [LANES-1:0]  lane_n;

    assign accept   = req_valid && (state == ST_IDLE);
    assign tmr_load = (accept && !req_write) || (state == ST_WR_SETUP);

    sram_lane_timer #(.CYCLES(ACC_CYC)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .done (tmr_done)
    );

    sram_lane_merge #(.LANES(LANES)) u_merge (
        .raw     (mem_dq_in),
        .use_lane(mask_q),
        .merged  (merged)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (accept) state_nx = req_write ? ST_WR_SETUP : ST_RD_WAIT;
            ST_RD_WAIT:  if (tmr_done) state_nx = ST_RD_TURN;
            ST_RD_TURN:  state_nx = ST_IDLE;
            ST_WR_SETUP: state_nx = ST_WR_PULSE;
            ST_WR_PULSE: if (tmr_done) state_nx = ST_WR_HOLD;
            ST_WR_HOLD:  state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // state and request registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
            rdata_q <= '0;
            rsp_q   <= 1'b0;
        end else begin
            state <= state_nx;
            rsp_q <= (state == ST_RD_WAIT) && tmr_done;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
            end
            if ((state == ST_RD_WAIT) && tmr_done)
                rdata_q <= merged;
        end
    end

    // output decode
    always_comb begin
        active    = 1'b0;
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        req_ready = 1'b0;
        unique case (state)
            ST_IDLE:     req_ready = 1'b1;
            ST_RD_WAIT:  begin active = 1'b1; mem_ce_n = 1'b0; mem_oe_n = 1'b0; end
            ST_RD_TURN:  ;
            ST_WR_SETUP: begin active = 1'b1; mem_ce_n = 1'b0; mem_dq_oe = 1'b1; end
            ST_WR_PULSE: begin active = 1'b1; mem_ce_n = 1'b0; mem_dq_oe = 1'b1; mem_we_n = 1'b0; end
            ST_WR_HOLD:  begin active = 1'b1; mem_ce_n = 1'b0; mem_dq_oe = 1'b1; end
            default:     ;
        endcase
        lane_n = active ? ~mask_q : '1;
    end

    assign mem_lb_n   = lane_n[0];
    assign mem_ub_n   = lane_n[LANES-1];
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_valid  = rsp_q;
    assign rsp_rdata  = rdata_q;

    // checks beside the logic
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n) |-> $stable(mem_addr));
    assert_we_rise_inside_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe));
    assert_rsp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    assert_turnaround_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n) |=> !mem_dq_oe);
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n));
endmodule

// File: tb/sim_sram_lane_ctrl.sv
module sim_sram_lane_ctrl;
    localparam int PERIOD  = 10;
    localparam int ACC_CYC = 2;   // R8: ceil(15000/10000)

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
    logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in;
    logic [17:0] mem_addr;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    sram_lane_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // memory model: lane-masked writes, data valid only after the access delay
    logic [15:0] mem_arr [256];
    logic [15:0] shadow  [256];
    int age = 0;
    logic [17:0] last_addr = '0;
    logic prev_oe_n = 1'b1;

    initial for (int i = 0; i < 256; i++) begin mem_arr[i] = 16'h0; shadow[i] = 16'h0; end

    always_comb begin
        logic [15:0] w;
        w = (age >= ACC_CYC - 1) ? mem_arr[mem_addr[7:0]] : 16'hDEAD;
        mem_dq_in[15:8] = (!mem_ce_n && !mem_oe_n && !mem_ub_n) ? w[15:8] : 8'hA5;
        mem_dq_in[7:0]  = (!mem_ce_n && !mem_oe_n && !mem_lb_n) ? w[7:0]  : 8'hA5;
    end

    always @(posedge clk) begin
        if (!mem_ce_n && !mem_oe_n && mem_we_n && mem_addr == last_addr) age <= age + 1;
        else age <= 0;
        last_addr <= mem_addr;
        if (!mem_ce_n && !mem_we_n) begin
            if (!mem_ub_n) mem_arr[mem_addr[7:0]][15:8] <= mem_dq_oe ? mem_dq_out[15:8] : 8'hEE;
            if (!mem_lb_n) mem_arr[mem_addr[7:0]][7:0]  <= mem_dq_oe ? mem_dq_out[7:0]  : 8'hEE;
        end
    end

    // per-cycle protocol watch
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!mem_we_n && !mem_oe_n) begin
                fails++; $display("FAIL R9: we_n=%b oe_n=%b expected not both 0", mem_we_n, mem_oe_n);
            end
            if (mem_dq_oe && !prev_oe_n) begin
                fails++; $display("FAIL R7: dq_oe=%b after oe_n low, expected 0", mem_dq_oe);
            end
            if (mem_dq_oe && !mem_oe_n) begin
                fails++; $display("FAIL R7: dq_oe=%b during read, expected 0", mem_dq_oe);
            end
        end
        prev_oe_n = mem_oe_n;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
        int lows = 0;
        issue(1'b1, a, d, m);
        // first cycle after accept: setup phase
        check(mem_we_n && !mem_ce_n && mem_dq_oe, "R3 setup", {mem_we_n, mem_ce_n, mem_dq_oe}, 3'b101);
        check({mem_ub_n, mem_lb_n} == ~m, "R4 write lanes", {mem_ub_n, mem_lb_n}, ~m);
        check(!req_ready, "R2 busy", req_ready, 0);
        check(mem_dq_out == d, "R3 data", mem_dq_out, d);
        @(negedge clk);
        while (!mem_we_n && lows < 20) begin lows++; @(negedge clk); end
        check(lows == ACC_CYC, "R3 pulse length", lows, ACC_CYC);
        check(!mem_ce_n && mem_dq_oe && mem_addr == a, "R3 hold", {mem_ce_n, mem_dq_oe}, 2'b01);
        if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
        if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
    endtask

    task automatic do_read(input logic [17:0] a, input logic [1:0] m, input string tag);
        int n = 1;
        logic [15:0] exp;
        exp = shadow[a[7:0]] & {{8{m[1]}}, {8{m[0]}}};
        issue(1'b0, a, 16'h0, m);
        check(!mem_ce_n && !mem_oe_n && !mem_dq_oe, "R5 read strobes", {mem_ce_n, mem_oe_n, mem_dq_oe}, 0);
        check({mem_ub_n, mem_lb_n} == ~m, "R4 read lanes", {mem_ub_n, mem_lb_n}, ~m);
        while (!rsp_valid && n < 20) begin n++; @(negedge clk); end
        check(n == ACC_CYC + 1, "R5 latency", n, ACC_CYC + 1);
        check(rsp_rdata == exp, {"R6 data ", tag}, rsp_rdata, exp);
        @(negedge clk);
        check(!rsp_valid && req_ready, "R5 single pulse", {rsp_valid, req_ready}, 2'b01);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(mem_ce_n && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !mem_dq_oe && req_ready,
              "R1 reset state", {mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready}, 7'b1111101);
    endtask

    task automatic t_full_word;
        do_write(18'h00012, 16'hBEEF, 2'b11);
        do_read(18'h00012, 2'b11, "full");
    endtask

    task automatic t_partial_writes;
        do_write(18'h00012, 16'h77AA, 2'b10);   // R4 upper only
        do_read(18'h00012, 2'b11, "after upper");
        do_write(18'h00012, 16'h5511, 2'b01);   // R4 lower only
        do_read(18'h00012, 2'b11, "after lower");
    endtask

    task automatic t_lane_reads;
        do_read(18'h00012, 2'b10, "upper lane");  // R6 lower zeroed
        do_read(18'h00012, 2'b01, "lower lane");  // R6 upper zeroed
        do_read(18'h00012, 2'b00, "no lane");
    endtask

    task automatic t_high_addr_turnaround;
        do_write(18'h3FF34, 16'h1234, 2'b11);
        check(mem_addr == 18'h3FF34, "R3 address", mem_addr, 18'h3FF34);
        do_read(18'h3FF34, 2'b11, "high addr");
        do_write(18'h00056, 16'hC0DE, 2'b11);  // read then write: R7 watch
        do_read(18'h00056, 2'b11, "after turn");
    endtask

    task automatic t_held_valid;
        // valid held through a whole read: second accept only after IDLE
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00056; req_mask = 2'b11;
        @(negedge clk);
        check(!req_ready, "R2 busy while held", req_ready, 0);
        repeat (ACC_CYC) @(negedge clk);
        check(rsp_valid, "R5 held read pulse", rsp_valid, 1);
        @(negedge clk);
        check(req_ready, "R2 ready again", req_ready, 1);
        req_valid = 1'b0;
        @(negedge clk);
        repeat (ACC_CYC + 2) @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_word();
        t_partial_writes();
        t_lane_reads();
        t_high_addr_turnaround();
        t_held_valid();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule